// File: doc/BRIEF.md
# PATA PIO Register Cycle Sequencer

This block turns a one-clock host request into a single programmed-I/O bus cycle toward a CompactFlash card in True IDE mode. The host names the register space (command block or alternate status/control), the register index (taken from the even host byte address bits 3:1), the direction and, for writes, the data. The block then drives the two chip selects, the register address, the read or write strobe and the 16-bit data bus, and it samples read data. Completion is marked by a one-clock done pulse.

All bus timing is counted in clocks from three programmable counts: strobe setup, strobe pulse and total cycle. The hardware adjusts them before use. It adds one clock to the setup. It treats a zero pulse as one clock. It stretches the cycle so that at least two recovery clocks follow the strobe. After reset the counts describe the slowest PIO mode (600 ns cycle, 70 ns setup, 290 ns pulse), rounded up to whole clocks of the design clock. Only the data register moves 16 bits. Every other register travels on the low byte. A device ready line, sampled at the last pulse clock, lengthens the strobe for as long as it reads not-ready.

Top module: `pata_pio_seq`

## Requirements
- R1: While reset is asserted and after its release, cf_cs0_n, cf_cs1_n, cf_rd_n and cf_wr_n are 1, and rsp_done and cf_doe are 0. The timing counts reset to ceil(70/T) setup, ceil(290/T) pulse and ceil(600/T) cycle clocks for a clock period of T ns. At 8 ns this gives 9, 37 and 75.
- R2: A request is accepted at the rising edge where req_start is 1 and no cycle is running. Call that edge the accept edge. The strobe asserts at rising edge setup+1 after the accept edge.
- R3: With S = setup+1, P = max(pulse,1) and C = max(cycle, S+P+2), the strobe stays low for P clocks and the cycle lasts C clocks.
- R4: A chip select asserts at the first edge after the accept edge and stays low for C-2 clocks. Command-block space (req_alt=0) drives cf_cs0_n low and keeps cf_cs1_n high. Alternate space (req_alt=1) does the opposite, and its control/alternate status register is index 6. The two selects are never low together, and a strobe is low only while a select is low.
- R5: A write uses the same S, P and C as a read, with cf_wr_n in place of cf_rd_n. cf_doe is 1 and cf_dout carries the write data exactly while the chip select is low. Otherwise cf_doe is 0 and cf_dout is 0.
- R6: Read data is taken from cf_din at the edge where cf_rd_n returns high and is held on rsp_rdata. Only command-block index 0 moves 16 bits. Any other register reads as {8'h00, cf_din[7:0]} and writes as {8'h00, req_wdata[7:0]}.
- R7: cf_addr equals the requested req_haddr[3:1] and is stable while the chip select is low. It is 0 otherwise.
- R8: When cf_ready is 0 at the edge that would end the last strobe clock, the strobe, the chip select and the cycle each stretch by one clock. This repeats for every such edge.
- R9: rsp_done is a one-clock pulse, high in the clock after the final recovery clock, C clocks after the accept edge. A req_start that arrives while a cycle is running is ignored and produces no extra cycle or done.
- R10: A timing-count write made during a cycle leaves that cycle unchanged and takes effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the three timing counts |
| cfg_setup | input | CNT_W | Strobe setup count, in clocks |
| cfg_pulse | input | CNT_W | Strobe pulse count, in clocks |
| cfg_cycle | input | CNT_W | Total cycle count, in clocks |
| req_start | input | 1 | Start a bus cycle (one clock) |
| req_alt | input | 1 | 0 = command-block space, 1 = alternate status/control space |
| req_haddr | input | 3 | Host byte address bits 3:1, giving the register index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Last captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| cf_cs0_n | output | 1 | Command-block chip select, active low |
| cf_cs1_n | output | 1 | Alternate-space chip select, active low |
| cf_rd_n | output | 1 | Read strobe, active low |
| cf_wr_n | output | 1 | Write strobe, active low |
| cf_addr | output | 3 | Device register address |
| cf_dout | output | DATA_W | Data driven to the device |
| cf_doe | output | 1 | Data output enable |
| cf_din | input | DATA_W | Data from the device |
| cf_ready | input | 1 | Device ready, 0 = stretch the strobe |

## Verification
Each pin moves at a fixed edge counted from the accept edge. The chip select and the address change one edge later, and the strobe changes setup+1 edges later. The read data updates at the edge that ends the strobe, and done comes C edges after acceptance. Every not-ready sample shifts the later events by one edge. The bench's reference model advances at the same rising edges as the design and is compared with every output at the following falling edge, so each expected value is checked in the clock where it is due. Directed transfers also count, in falling-edge samples, the strobe offset, the strobe and chip-select widths and the done latency, and compare them with hand-derived clock counts.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

   localparam int REG_IDX_W    = 3;
   localparam int BYTE_W       = 8;
   localparam int DATA_REG_IDX = 0;
   localparam int ALT_CTRL_IDX = 6;

   typedef enum logic [1:0] {
      SPACE_NONE = 2'b00,
      SPACE_TASK = 2'b01,
      SPACE_ALT  = 2'b10
   } space_e;

   function automatic logic is_wide_reg(input logic alt, input logic [REG_IDX_W-1:0] idx);
      return (!alt) && (idx == REG_IDX_W'(DATA_REG_IDX));
   endfunction

   function automatic int ns_to_clk(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

endpackage

// File: rtl/pata_timing_clamp.sv
module pata_timing_clamp #(
   parameter int CNT_W        = 8,
   parameter int CYC_W        = CNT_W + 2,
   parameter int MIN_RECOVERY = 2
) (
   input  logic [CNT_W-1:0] setup_cnt,
   input  logic [CNT_W-1:0] pulse_cnt,
   input  logic [CNT_W-1:0] cycle_cnt,
   output logic [CYC_W-1:0] strobe_first,
   output logic [CYC_W-1:0] strobe_last,
   output logic [CYC_W-1:0] cycle_last
);

   localparam logic [CYC_W-1:0] ONE_C = CYC_W'(1);
   localparam logic [CYC_W-1:0] REC_C = CYC_W'(MIN_RECOVERY);

   generate
      if (CYC_W < CNT_W + 2) begin : g_bad_width
         $error("CYC_W must exceed CNT_W by at least two bits");
      end
      if (MIN_RECOVERY < 1) begin : g_bad_recovery
         $error("MIN_RECOVERY must be at least one clock");
      end
   endgenerate

   logic [CYC_W-1:0] s_eff;
   logic [CYC_W-1:0] p_eff;
   logic [CYC_W-1:0] active;
   logic [CYC_W-1:0] need;
   logic [CYC_W-1:0] c_req;
   logic [CYC_W-1:0] c_eff;

   always_comb begin
      s_eff  = CYC_W'(setup_cnt) + ONE_C;
      p_eff  = (pulse_cnt == '0) ? ONE_C : CYC_W'(pulse_cnt);
      active = s_eff + p_eff;
      need   = active + REC_C;
      c_req  = CYC_W'(cycle_cnt);
      c_eff  = (c_req < need) ? need : c_req;
      strobe_first = s_eff;
      strobe_last  = active - ONE_C;
      cycle_last   = c_eff - ONE_C;
   end

endmodule

// File: rtl/pata_cycle_ctrl.sv
module pata_cycle_ctrl #(
   parameter int CYC_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ready,
   input  logic [CYC_W-1:0] strobe_first_in,
   input  logic [CYC_W-1:0] strobe_last_in,
   input  logic [CYC_W-1:0] cycle_last_in,
   output logic             accept,
   output logic             capture,
   output logic             cs_phase_d,
   output logic             strobe_phase_d,
   output logic             done
);

   localparam logic [CYC_W-1:0] ONE_C = CYC_W'(1);

   logic             busy;
   logic [CYC_W-1:0] k;
   logic [CYC_W-1:0] sf_q;
   logic [CYC_W-1:0] sl_q;
   logic [CYC_W-1:0] cl_q;

   logic             busy_n;
   logic [CYC_W-1:0] k_n;
   logic             done_n;
   logic             hold;
   logic [CYC_W-1:0] use_sf;
   logic [CYC_W-1:0] use_sl;
   logic [CYC_W-1:0] use_cl;

   always_comb begin
      accept  = start && !busy;
      hold    = busy && (k == sl_q) && !ready;
      capture = busy && (k == sl_q) && ready;
      use_sf  = accept ? strobe_first_in : sf_q;
      use_sl  = accept ? strobe_last_in  : sl_q;
      use_cl  = accept ? cycle_last_in   : cl_q;
      busy_n  = busy;
      k_n     = k;
      done_n  = 1'b0;
      if (accept) begin
         busy_n = 1'b1;
         k_n    = '0;
      end else if (busy) begin
         if (hold) begin
            k_n = k;
         end else if (k == cl_q) begin
            busy_n = 1'b0;
            k_n    = '0;
            done_n = 1'b1;
         end else begin
            k_n = k + ONE_C;
         end
      end
      cs_phase_d     = busy_n && (k_n != '0) && (k_n < use_cl);
      strobe_phase_d = busy_n && (k_n >= use_sf) && (k_n <= use_sl);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         k    <= '0;
         sf_q <= ONE_C;
         sl_q <= ONE_C;
         cl_q <= CYC_W'(3);
         done <= 1'b0;
      end else begin
         busy <= busy_n;
         k    <= k_n;
         done <= done_n;
         if (accept) begin
            sf_q <= strobe_first_in;
            sl_q <= strobe_last_in;
            cl_q <= cycle_last_in;
         end
      end
   end

   AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(accept)) |-> ($stable(cl_q) && $stable(sl_q))); // R10

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy || $past(accept)); // R9

endmodule

// File: rtl/pata_bus_drive.sv
module pata_bus_drive
   import pata_pio_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic                 capture,
   input  logic                 cs_phase_d,
   input  logic                 strobe_phase_d,
   input  logic                 req_alt,
   input  logic [REG_IDX_W-1:0] req_idx,
   input  logic                 req_write,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [DATA_W-1:0]    cf_din,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic                 cf_cs0_n,
   output logic                 cf_cs1_n,
   output logic                 cf_rd_n,
   output logic                 cf_wr_n,
   output logic [REG_IDX_W-1:0] cf_addr,
   output logic [DATA_W-1:0]    cf_dout,
   output logic                 cf_doe
);

   localparam int HI_W = DATA_W - BYTE_W;

   space_e               space_q;
   logic [REG_IDX_W-1:0] idx_q;
   logic                 wr_q;
   logic                 wide_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [DATA_W-1:0]    rd_lane;
   logic [DATA_W-1:0]    wr_lane;
   logic                 req_wide;

   always_comb begin
      req_wide = is_wide_reg(req_alt, req_idx);
      wr_lane  = req_wide ? req_wdata : {{HI_W{1'b0}}, req_wdata[BYTE_W-1:0]};
      rd_lane  = wide_q   ? cf_din    : {{HI_W{1'b0}}, cf_din[BYTE_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         space_q   <= SPACE_NONE;
         idx_q     <= '0;
         wr_q      <= 1'b0;
         wide_q    <= 1'b0;
         wdata_q   <= '0;
         rsp_rdata <= '0;
         cf_cs0_n  <= 1'b1;
         cf_cs1_n  <= 1'b1;
         cf_rd_n   <= 1'b1;
         cf_wr_n   <= 1'b1;
         cf_addr   <= '0;
         cf_dout   <= '0;
         cf_doe    <= 1'b0;
      end else begin
         if (accept) begin
            space_q <= req_alt ? SPACE_ALT : SPACE_TASK;
            idx_q   <= req_idx;
            wr_q    <= req_write;
            wide_q  <= req_wide;
            wdata_q <= wr_lane;
         end
         if (capture && !wr_q) begin
            rsp_rdata <= rd_lane;
         end
         cf_cs0_n <= !(cs_phase_d && (space_q == SPACE_TASK));
         cf_cs1_n <= !(cs_phase_d && (space_q == SPACE_ALT));
         cf_rd_n  <= !(strobe_phase_d && !wr_q);
         cf_wr_n  <= !(strobe_phase_d && wr_q);
         cf_addr  <= cs_phase_d ? idx_q : '0;
         cf_doe   <= cs_phase_d && wr_q;
         cf_dout  <= (cs_phase_d && wr_q) ? wdata_q : '0;
      end
   end

   AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cf_cs0_n || cf_cs1_n); // R4

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cf_rd_n || !cf_wr_n) |-> (!cf_cs0_n || !cf_cs1_n)); // R4

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      cf_rd_n || cf_wr_n); // R5

   AST_DRIVE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      cf_doe |-> (!cf_cs0_n || !cf_cs1_n)); // R5

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((!cf_cs0_n || !cf_cs1_n) && $past(!cf_cs0_n || !cf_cs1_n)) |-> $stable(cf_addr)); // R7

   AST_RDATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> $rose(cf_rd_n)); // R6

endmodule

// File: rtl/pata_pio_seq.sv
module pata_pio_seq
   import pata_pio_pkg::*;
#(
   parameter int CLK_PERIOD_NS = 8,
   parameter int CNT_W         = 8,
   parameter int DATA_W        = 16,
   parameter int MIN_RECOVERY  = 2,
   parameter int READY_SYNC    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CNT_W-1:0]     cfg_setup,
   input  logic [CNT_W-1:0]     cfg_pulse,
   input  logic [CNT_W-1:0]     cfg_cycle,
   input  logic                 req_start,
   input  logic                 req_alt,
   input  logic [REG_IDX_W:1]   req_haddr,
   input  logic                 req_write,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic                 rsp_done,
   output logic                 cf_cs0_n,
   output logic                 cf_cs1_n,
   output logic                 cf_rd_n,
   output logic                 cf_wr_n,
   output logic [REG_IDX_W-1:0] cf_addr,
   output logic [DATA_W-1:0]    cf_dout,
   output logic                 cf_doe,
   input  logic [DATA_W-1:0]    cf_din,
   input  logic                 cf_ready
);

   localparam int CYC_W     = CNT_W + 2;
   localparam int RST_SETUP = ns_to_clk(70,  CLK_PERIOD_NS);
   localparam int RST_PULSE = ns_to_clk(290, CLK_PERIOD_NS);
   localparam int RST_CYCLE = ns_to_clk(600, CLK_PERIOD_NS);

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be positive");
      end
      if (DATA_W <= BYTE_W) begin : g_bad_data
         $error("DATA_W must be wider than one byte lane");
      end
      if (RST_CYCLE >= (1 << CNT_W) || RST_PULSE >= (1 << CNT_W)) begin : g_bad_cnt
         $error("CNT_W too narrow for the reset timing at this clock period");
      end
      if (READY_SYNC < 0) begin : g_bad_sync
         $error("READY_SYNC must not be negative");
      end
   endgenerate

   logic [CNT_W-1:0] setup_q;
   logic [CNT_W-1:0] pulse_q;
   logic [CNT_W-1:0] cycle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q <= CNT_W'(RST_SETUP);
         pulse_q <= CNT_W'(RST_PULSE);
         cycle_q <= CNT_W'(RST_CYCLE);
      end else if (cfg_wr) begin
         setup_q <= cfg_setup;
         pulse_q <= cfg_pulse;
         cycle_q <= cfg_cycle;
      end
   end

   logic ready_int;

   generate
      if (READY_SYNC == 0) begin : g_rdy_direct
         assign ready_int = cf_ready;
      end else begin : g_rdy_sync
         logic [READY_SYNC-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
            end else begin
               sync_q <= (sync_q << 1) | READY_SYNC'(cf_ready);
            end
         end
         assign ready_int = sync_q[READY_SYNC-1];
      end
   endgenerate

   logic [CYC_W-1:0] strobe_first;
   logic [CYC_W-1:0] strobe_last;
   logic [CYC_W-1:0] cycle_last;
   logic             accept;
   logic             capture;
   logic             cs_phase_d;
   logic             strobe_phase_d;

   pata_timing_clamp #(
      .CNT_W        (CNT_W),
      .CYC_W        (CYC_W),
      .MIN_RECOVERY (MIN_RECOVERY)
   ) u_clamp (
      .setup_cnt    (setup_q),
      .pulse_cnt    (pulse_q),
      .cycle_cnt    (cycle_q),
      .strobe_first (strobe_first),
      .strobe_last  (strobe_last),
      .cycle_last   (cycle_last)
   );

   pata_cycle_ctrl #(
      .CYC_W (CYC_W)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .start           (req_start),
      .ready           (ready_int),
      .strobe_first_in (strobe_first),
      .strobe_last_in  (strobe_last),
      .cycle_last_in   (cycle_last),
      .accept          (accept),
      .capture         (capture),
      .cs_phase_d      (cs_phase_d),
      .strobe_phase_d  (strobe_phase_d),
      .done            (rsp_done)
   );

   pata_bus_drive #(
      .DATA_W (DATA_W)
   ) u_bus (
      .clk            (clk),
      .rst_n          (rst_n),
      .accept         (accept),
      .capture        (capture),
      .cs_phase_d     (cs_phase_d),
      .strobe_phase_d (strobe_phase_d),
      .req_alt        (req_alt),
      .req_idx        (req_haddr),
      .req_write      (req_write),
      .req_wdata      (req_wdata),
      .cf_din         (cf_din),
      .rsp_rdata      (rsp_rdata),
      .cf_cs0_n       (cf_cs0_n),
      .cf_cs1_n       (cf_cs1_n),
      .cf_rd_n        (cf_rd_n),
      .cf_wr_n        (cf_wr_n),
      .cf_addr        (cf_addr),
      .cf_dout        (cf_dout),
      .cf_doe         (cf_doe)
   );

   AST_STROBE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cf_cs0_n) || $fell(cf_cs1_n) |-> ($past(cf_cs0_n) && $past(cf_cs1_n))); // R4

endmodule

// File: tb/tb_pata_pio_seq.sv
module tb_pata_pio_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_setup = '0;
   logic [7:0]  cfg_pulse = '0;
   logic [7:0]  cfg_cycle = '0;
   logic        req_start = 1'b0;
   logic        req_alt = 1'b0;
   logic [3:1]  req_haddr = '0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [15:0] rsp_rdata;
   logic        rsp_done;
   logic        cf_cs0_n, cf_cs1_n, cf_rd_n, cf_wr_n, cf_doe;
   logic [2:0]  cf_addr;
   logic [15:0] cf_dout;
   logic [15:0] cf_din = 16'hA5C3;
   logic        cf_ready = 1'b1;

   always #4 clk = ~clk;

   pata_pio_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_setup(cfg_setup),
      .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .req_start(req_start),
      .req_alt(req_alt), .req_haddr(req_haddr), .req_write(req_write),
      .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .cf_cs0_n(cf_cs0_n), .cf_cs1_n(cf_cs1_n), .cf_rd_n(cf_rd_n),
      .cf_wr_n(cf_wr_n), .cf_addr(cf_addr), .cf_dout(cf_dout), .cf_doe(cf_doe),
      .cf_din(cf_din), .cf_ready(cf_ready)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model, advanced on the same rising edges as the design
   int m_set, m_pul, m_cyc, m_S, m_P, m_C, m_n;
   bit m_busy, m_done, m_alt, m_wr, m_wide;
   logic [2:0]  m_idx;
   logic [15:0] m_wd, m_rdata;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_set = 9; m_pul = 37; m_cyc = 75;
         m_busy = 0; m_done = 0; m_n = 0; m_rdata = '0;
         m_alt = 0; m_wr = 0; m_idx = '0; m_wd = '0; m_wide = 0;
         m_S = 1; m_P = 1; m_C = 4;
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (m_n == m_S + m_P - 1 && !cf_ready) begin
               m_n = m_n;
            end else begin
               if (m_n == m_S + m_P - 1 && !m_wr)
                  m_rdata = m_wide ? cf_din : {8'h00, cf_din[7:0]};
               if (m_n == m_C - 1) begin
                  m_busy = 0; m_done = 1;
               end else begin
                  m_n++;
               end
            end
         end else if (req_start) begin
            m_S = m_set + 1;
            m_P = (m_pul == 0) ? 1 : m_pul;
            m_C = (m_cyc < m_S + m_P + 2) ? m_S + m_P + 2 : m_cyc;
            m_alt = req_alt; m_idx = req_haddr; m_wr = req_write;
            m_wide = !req_alt && req_haddr == 3'd0;
            m_wd = m_wide ? req_wdata : {8'h00, req_wdata[7:0]};
            m_busy = 1; m_n = 0;
         end
         if (cfg_wr) begin
            m_set = cfg_setup; m_pul = cfg_pulse; m_cyc = cfg_cycle;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit cs, stb;
         cs  = m_busy && m_n >= 1 && m_n <= m_C - 2;
         stb = m_busy && m_n >= m_S && m_n <= m_S + m_P - 1;
         chk("R4 cf_cs0_n", cf_cs0_n, !(cs && !m_alt));
         chk("R4 cf_cs1_n", cf_cs1_n, !(cs && m_alt));
         chk("R2 cf_rd_n", cf_rd_n, !(stb && !m_wr));
         chk("R5 cf_wr_n", cf_wr_n, !(stb && m_wr));
         chk("R5 cf_doe", cf_doe, cs && m_wr);
         chk("R6 cf_dout", cf_dout, (cs && m_wr) ? m_wd : 16'h0);
         chk("R7 cf_addr", cf_addr, cs ? m_idx : 3'd0);
         chk("R9 rsp_done", rsp_done, m_done);
         chk("R6 rsp_rdata", rsp_rdata, m_rdata);
      end
   end

   // directed transfer with measurement
   int r_first, r_stb, r_cs, r_done;
   bit r_rd, r_wr, r_cs0, r_cs1, r_doe;
   logic [2:0]  r_addr;
   logic [15:0] r_dout;

   task automatic set_cfg(input int s, input int p, input int c);
      @(negedge clk);
      cfg_wr = 1; cfg_setup = 8'(s); cfg_pulse = 8'(p); cfg_cycle = 8'(c);
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic xfer(input logic alt, input logic [3:0] ha, input logic wr,
                       input logic [15:0] wd, input int rel_at,
                       input bit poke_start, input bit poke_cfg);
      int i;
      @(negedge clk);
      req_start = 1; req_alt = alt; req_haddr = ha[3:1]; req_write = wr; req_wdata = wd;
      @(negedge clk);
      req_start = 0;
      i = 0; r_first = -1; r_stb = 0; r_cs = 0; r_done = -1;
      r_rd = 0; r_wr = 0; r_cs0 = 0; r_cs1 = 0; r_doe = 0; r_addr = '0; r_dout = '0;
      while (r_done < 0 && i < 400) begin
         if (rel_at >= 0 && i == rel_at) cf_ready = 1;
         if (poke_start && i == 2) req_start = 1;
         if (poke_start && i == 3) req_start = 0;
         if (poke_cfg && i == 2) begin
            cfg_wr = 1; cfg_setup = 8'd1; cfg_pulse = 8'd2; cfg_cycle = 8'd3;
         end
         if (poke_cfg && i == 3) cfg_wr = 0;
         if (!cf_cs0_n || !cf_cs1_n) begin
            r_cs++; r_addr = cf_addr; r_dout = cf_dout; r_doe = cf_doe;
         end
         if (!cf_rd_n || !cf_wr_n) begin
            if (r_first < 0) r_first = i;
            r_stb++;
         end
         if (!cf_rd_n) r_rd = 1;
         if (!cf_wr_n) r_wr = 1;
         if (!cf_cs0_n) r_cs0 = 1;
         if (!cf_cs1_n) r_cs1 = 1;
         if (rsp_done) r_done = i;
         @(negedge clk);
         i++;
      end
   endtask

   task automatic expect_timing(input string tag, input int first, input int stb,
                                input int cs, input int dn);
      chk({tag, " strobe offset"}, r_first, first);
      chk({tag, " strobe width"}, r_stb, stb);
      chk({tag, " cs width"}, r_cs, cs);
      chk({tag, " done latency"}, r_done, dn);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cs0 in reset", cf_cs0_n, 1);
      chk("R1 cs1 in reset", cf_cs1_n, 1);
      chk("R1 rd in reset", cf_rd_n, 1);
      chk("R1 wr in reset", cf_wr_n, 1);
      chk("R1 done in reset", rsp_done, 0);
      chk("R1 doe in reset", cf_doe, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 strobes after reset", {cf_cs0_n, cf_cs1_n, cf_rd_n, cf_wr_n}, 4'hF);

      // R1 reset timing 9/37/75 -> S=10 P=37 C=75; R2 R3 R4 R6
      xfer(0, 4'h0, 0, 16'h0, -1, 0, 0);
      expect_timing("R1 R2 R3 reset timing", 10, 37, 73, 75);
      chk("R6 wide read", rsp_rdata, 16'hA5C3);
      chk("R4 taskfile uses cs0", {r_cs0, r_cs1}, 2'b10);
      chk("R5 read uses rd only", {r_rd, r_wr}, 2'b10);

      // R3 clamp: 1/2/3 -> S=2 P=2 C=6; R5 R6 R7 narrow write
      set_cfg(1, 2, 3);
      xfer(0, 4'h2, 1, 16'hBEEF, -1, 0, 0);
      expect_timing("R3 R5 clamped write", 2, 2, 4, 6);
      chk("R6 narrow write lane", r_dout, 16'h00EF);
      chk("R5 doe during cs", r_doe, 1);
      chk("R7 address idx1", r_addr, 3'd1);
      chk("R5 write uses wr only", {r_rd, r_wr}, 2'b01);

      // R3 long cycle: 2/3/20 -> S=3 P=3 C=20
      set_cfg(2, 3, 20);
      cf_din = 16'h7E5A;
      xfer(0, 4'h4, 0, 16'h0, -1, 0, 0);
      expect_timing("R3 R4 long cycle read", 3, 3, 18, 20);
      chk("R7 address idx2", r_addr, 3'd2);
      chk("R6 narrow read lane", rsp_rdata, 16'h005A);

      xfer(0, 4'h0, 1, 16'h1234, -1, 0, 0);
      expect_timing("R5 write same timing", 3, 3, 18, 20);
      chk("R6 wide write", r_dout, 16'h1234);

      // R4 alternate space, register 6
      cf_din = 16'h3C81;
      xfer(1, 4'hC, 0, 16'h0, -1, 0, 0);
      chk("R4 alt uses cs1", {r_cs0, r_cs1}, 2'b01);
      chk("R7 alt address", r_addr, 3'd6);
      chk("R6 alt narrow read", rsp_rdata, 16'h0081);

      // R3 zero counts -> S=1 P=1 C=4
      set_cfg(0, 0, 0);
      xfer(0, 4'h6, 0, 16'h0, -1, 0, 0);
      expect_timing("R3 zero counts", 1, 1, 2, 4);

      // R8 ready low for three edges at the last pulse clock
      set_cfg(1, 2, 3);
      cf_ready = 0;
      xfer(0, 4'h0, 0, 16'h0, 6, 0, 0);
      expect_timing("R8 ready stretch", 2, 5, 7, 9);

      // R9 start during busy ignored
      xfer(0, 4'h0, 1, 16'h5555, -1, 1, 0);
      expect_timing("R9 busy start", 2, 2, 4, 6);
      begin
         int extra;
         extra = 0;
         for (int j = 0; j < 12; j++) begin
            if (rsp_done || !cf_cs0_n || !cf_cs1_n) extra++;
            @(negedge clk);
         end
         chk("R9 no extra cycle", extra, 0);
      end

      // R10 timing write mid-cycle
      set_cfg(1, 2, 20);
      xfer(0, 4'h0, 0, 16'h0, -1, 0, 1);
      expect_timing("R10 current cycle kept", 2, 2, 18, 20);
      xfer(0, 4'h0, 0, 16'h0, -1, 0, 0);
      expect_timing("R10 next cycle updated", 2, 2, 4, 6);

      repeat (4) @(negedge clk);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule